// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card-side clock of an SD host from the host clock. A single control word selects the division ratio, turns the card clock output on or off, and can make the clock stop by itself whenever the bus has no command or data transfer in flight. The ratio field uses a sparse one-hot code. Each legal code gives a power-of-two ratio from 1 up to 512, and up to 1024 when the `HAS_DIV1024` parameter is set.

For every ratio of 2 or more, the card clock is the output of a toggle flop driven by a half-period counter. Divide-by-1 passes the host clock straight through a gate that is updated on the falling edge. Stopping and restarting never produce a shortened pulse. A stop waits for the current high phase to end, and a restart begins with a full low phase. The ratio can be changed only while the clock is disabled and already stopped. A code with more than one divider bit set, or an unsupported divide-by-1024 code, is rejected and flagged, and the previous ratio is kept.

Software writes the control word through `cfg_we`/`cfg_wdata`. The transfer engine drives `bus_busy` high while a command or data transfer is active.

Top module: `sdclk_div`

## Requirements
- R1: After reset, `sdclk_o` and `bad_code_o` are 0, the output is disabled, auto-stop is off, and the held ratio is divide-by-2.
- R2: The divider field is made of `cfg_wdata` bits 0..7, 10 and 16. Bit i (i = 0..7) alone selects divide-by-2^(i+2), that is 4 up to 512. All divider bits zero selects divide-by-2. Bit 10 alone selects divide-by-1. Bit 16 alone selects divide-by-1024 when `HAS_DIV1024` = 1.
- R3: For a ratio N ≥ 2, the output is low for N/2 host cycles and high for N/2 host cycles. The first low phase after the clock starts lasts a full N/2 cycles, counted from the edge that starts it.
- R4: At divide-by-1, while running, `sdclk_o` follows the host clock: high during the high phase of the host clock and low during its low phase. A change of the gate takes effect only while the host clock is low.
- R5: `cfg_wdata` bit 8 is the output enable. When the enable is cleared, a high phase in progress completes in full and the output then stays low. A low phase in progress ends at once, with the output held low.
- R6: `cfg_wdata` bit 9 enables auto-stop. While it is set, the clock runs only in cycles where `bus_busy` is 1, and the stop and restart rules of R3 and R5 apply.
- R7: A write replaces the ratio only if the enable held before the write is 0 and the clock is stopped. Otherwise the ratio is kept, while the enable and auto-stop bits of that write still take effect.
- R8: `bad_code_o` shows, from the cycle after each write, whether that write's divider field was illegal: more than one divider bit set, or bit 16 set with `HAS_DIV1024` = 0. An illegal write leaves the ratio unchanged. The next legal write clears the flag.
- R9: `cfg_wdata` bits 11..15 have no effect on the output or on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 17 | Control word: divider field, enable (bit 8), auto-stop (bit 9) |
| bus_busy | input | 1 | High while a command or data transfer is active |
| sdclk_o | output | 1 | Card clock |
| bad_code_o | output | 1 | The last written divider code was illegal |

## Verification
The assertions assume that `bus_busy`, `cfg_we` and `cfg_wdata` are synchronous to the host clock and change only away from its rising edge. They also assume that the divider field means something only in a cycle where `cfg_we` is high. The bench drives every input 2 ns after a rising edge and samples there too. The single exception is one extra sample taken in the low phase of the host clock to observe divide-by-1 gating. Ratio changes are attempted only after the bench's own model shows that the clock has fully stopped. Writes made while the clock is enabled are deliberate, and their purpose is to show that the ratio is held.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // control word layout
  localparam int CTRL_W      = 17;
  localparam int POW_BITS    = 8;   // bits 0..7: divide by 4 .. 512
  localparam int OE_BIT      = 8;
  localparam int AUTO_BIT    = 9;
  localparam int DIV1_BIT    = 10;
  localparam int DIV1024_BIT = 16;

  // decoded view
  localparam int SEL_W      = POW_BITS + 2;
  localparam int MAX_LOG2   = 10;
  localparam int LOG2_W     = $clog2(MAX_LOG2 + 1);
  localparam int CNT_W      = MAX_LOG2;
  localparam int RESET_LOG2 = 1;    // divide by 2

  typedef logic [LOG2_W-1:0] log2_t;

  typedef enum logic [1:0] {
    CODE_OK    = 2'd0,
    CODE_MULTI = 2'd1,
    CODE_UNSUP = 2'd2
  } code_st_e;

  // log2 of the ratio chosen by one bit of the gathered select vector
  function automatic log2_t sel_to_log2(int idx);
    if (idx < POW_BITS)       return log2_t'(idx + 2);
    else if (idx == POW_BITS) return log2_t'(0);
    else                      return log2_t'(MAX_LOG2);
  endfunction

  // packs the divider bits: [POW_BITS+1]=div1024, [POW_BITS]=div1, rest powers
  function automatic logic [SEL_W-1:0] gather_sel(logic [CTRL_W-1:0] w);
    return {w[DIV1024_BIT], w[DIV1_BIT], w[POW_BITS-1:0]};
  endfunction

endpackage

// File: rtl/sdclk_decode.sv
module sdclk_decode
  import sdclk_pkg::*;
#(
  parameter bit HAS_DIV1024 = 1'b1
) (
  input  logic [SEL_W-1:0] sel_i,
  output log2_t            log2_o,
  output code_st_e         status_o
);

  localparam int ONES_W = $clog2(SEL_W + 1);

  log2_t part [SEL_W];

  genvar g;
  generate
    for (g = 0; g < SEL_W; g++) begin : g_part
      assign part[g] = sel_i[g] ? sel_to_log2(g) : '0;
    end
  endgenerate

  log2_t             acc;
  logic [ONES_W-1:0] ones;

  always_comb begin
    acc  = '0;
    ones = '0;
    for (int i = 0; i < SEL_W; i++) begin
      acc  = acc | part[i];
      ones = ones + ONES_W'(sel_i[i]);
    end
  end

  always_comb begin
    status_o = CODE_OK;
    log2_o   = acc;
    if (ones == '0) begin
      log2_o = log2_t'(1);
    end else if (ones > ONES_W'(1)) begin
      status_o = CODE_MULTI;
    end else if (!HAS_DIV1024 && sel_i[SEL_W-1]) begin
      status_o = CODE_UNSUP;
    end
  end

endmodule

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     we_i,
  input  logic     oe_wr_i,
  input  logic     auto_wr_i,
  input  log2_t    dec_log2_i,
  input  code_st_e dec_status_i,
  input  logic     gen_idle_i,
  input  logic     busy_i,
  output logic     oe_o,
  output log2_t    log2_o,
  output logic     bad_o,
  output logic     run_o
);

  logic  oe_q;
  logic  auto_q;
  log2_t log2_q;
  logic  bad_q;
  logic  code_ok;
  logic  ratio_open;

  assign code_ok    = (dec_status_i == CODE_OK);
  assign ratio_open = !oe_q && gen_idle_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      auto_q <= 1'b0;
      log2_q <= log2_t'(RESET_LOG2);
      bad_q  <= 1'b0;
    end else if (we_i) begin
      oe_q   <= oe_wr_i;
      auto_q <= auto_wr_i;
      bad_q  <= !code_ok;
      if (code_ok && ratio_open) begin
        log2_q <= dec_log2_i;
      end
    end
  end

  assign run_o  = oe_q && (!auto_q || busy_i);
  assign oe_o   = oe_q;
  assign log2_o = log2_q;
  assign bad_o  = bad_q;

endmodule

// File: rtl/sdclk_toggle.sv
module sdclk_toggle
  import sdclk_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  run_i,
  input  log2_t log2_i,
  output logic  tog_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;
  logic             tog_q;
  logic             act;

  assign act     = run_i && (log2_i != '0);
  assign half_m1 = (CNT_W'(1) << (log2_i - log2_t'(1))) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (!tog_q && !act) begin
      cnt_q <= '0;
    end else if (cnt_q == half_m1) begin
      cnt_q <= '0;
      tog_q <= ~tog_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign tog_o = tog_q;

endmodule

// File: rtl/sdclk_pass.sv
module sdclk_pass
  import sdclk_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  run_i,
  input  log2_t log2_i,
  output logic  gate_o
);

  logic gate_q;

  // updated while clk is low, so the AND gate downstream sees no partial pulse
  always_ff @(negedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= run_i && (log2_i == '0);
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/sdclk_div.sv
module sdclk_div
  import sdclk_pkg::*;
#(
  parameter bit HAS_DIV1024 = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              bus_busy,
  output logic              sdclk_o,
  output logic              bad_code_o
);

  log2_t    dec_log2;
  code_st_e dec_status;
  logic     ctl_oe;
  log2_t    ctl_log2;
  logic     gen_run;
  logic     tog_lvl;
  logic     pass_gate;
  logic     gen_idle;
  logic     unused_rsvd;

  assign unused_rsvd = ^cfg_wdata[DIV1024_BIT-1:DIV1_BIT+1];

  sdclk_decode #(.HAS_DIV1024(HAS_DIV1024)) u_decode (
    .sel_i    (gather_sel(cfg_wdata)),
    .log2_o   (dec_log2),
    .status_o (dec_status)
  );

  sdclk_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .we_i         (cfg_we),
    .oe_wr_i      (cfg_wdata[OE_BIT]),
    .auto_wr_i    (cfg_wdata[AUTO_BIT]),
    .dec_log2_i   (dec_log2),
    .dec_status_i (dec_status),
    .gen_idle_i   (gen_idle),
    .busy_i       (bus_busy),
    .oe_o         (ctl_oe),
    .log2_o       (ctl_log2),
    .bad_o        (bad_code_o),
    .run_o        (gen_run)
  );

  sdclk_toggle u_toggle (
    .clk    (clk),
    .rst    (rst),
    .run_i  (gen_run),
    .log2_i (ctl_log2),
    .tog_o  (tog_lvl)
  );

  sdclk_pass u_pass (
    .clk    (clk),
    .rst    (rst),
    .run_i  (gen_run),
    .log2_i (ctl_log2),
    .gate_o (pass_gate)
  );

  assign gen_idle = !tog_lvl && !pass_gate;
  assign sdclk_o  = (ctl_log2 == '0) ? (clk & pass_gate) : tog_lvl;

endmodule

// File: rtl/sdclk_div_chk.sv
module sdclk_div_chk
  import sdclk_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [CTRL_W-1:0] cfg_wdata,
  input logic              bad_code_o,
  input logic              ctl_oe,
  input log2_t             ctl_log2,
  input logic              tog_lvl,
  input logic              gen_run
);

  logic multi_wr;
  assign multi_wr = cfg_we && ($countones(gather_sel(cfg_wdata)) > 1);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!bad_code_o && !tog_lvl));

  // R8
  multi_flag_chk: assert property (@(posedge clk) disable iff (rst)
    multi_wr |=> bad_code_o);

  // R8
  multi_keeps_ratio_chk: assert property (@(posedge clk) disable iff (rst)
    multi_wr |=> $stable(ctl_log2));

  // R7
  ratio_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_oe |=> $stable(ctl_log2));

  // R5
  stopped_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!gen_run && !tog_lvl) |=> !tog_lvl);

  // R3
  div2_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_run && ctl_log2 == log2_t'(1)) |=> (tog_lvl != $past(tog_lvl)));

endmodule

bind sdclk_div sdclk_div_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_wdata  (cfg_wdata),
  .bad_code_o (bad_code_o),
  .ctl_oe     (ctl_oe),
  .ctl_log2   (ctl_log2),
  .tog_lvl    (tog_lvl),
  .gen_run    (gen_run)
);

// File: tb/sdclk_div_tb_top.sv
module sdclk_div_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [16:0] cfg_wdata = '0;
  logic        bus_busy = 1'b0;
  logic        sdclk, bad, sdclk2, bad2;

  always #4 clk = ~clk;

  sdclk_div #(.HAS_DIV1024(1'b1)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bus_busy(bus_busy), .sdclk_o(sdclk), .bad_code_o(bad));

  sdclk_div #(.HAS_DIV1024(1'b0)) dut_nod (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bus_busy(bus_busy), .sdclk_o(sdclk2), .bad_code_o(bad2));

  int    n_vec = 0;
  int    n_miss = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model state
  bit m_en = 0, m_auto = 0, m_act = 0, m_bad = 0, m_bad2 = 0;
  int m_k = 1, m_n = 0;

  function automatic int lvl(int k, int n);
    int h = 1 << (k - 1);
    return (n / h) % 2;
  endfunction

  function automatic logic [16:0] enc(int k);
    if (k == 0)      return 17'h00400;
    else if (k == 1) return 17'h00000;
    else if (k <= 9) return 17'(1 << (k - 2));
    else             return 17'h10000;
  endfunction

  function automatic int dec_k(logic [16:0] w, bit has, output bit ill);
    int ones = 0;
    int k = 1;
    ill = 0;
    for (int i = 0; i < 8; i++) if (w[i]) begin ones++; k = i + 2; end
    if (w[10]) begin ones++; k = 0; end
    if (w[16]) begin ones++; k = 10; if (!has) ill = 1; end
    if (ones > 1) ill = 1;
    if (ones == 0) k = 1;
    return k;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    bit r, we_s, idle_b, en_b, ill, ill2, expv;
    logic [16:0] d;
    int nk;
    r = m_en && (!m_auto || bus_busy);
    we_s = cfg_we; d = cfg_wdata; idle_b = !m_act; en_b = m_en;
    @(posedge clk); #2;
    if (m_k == 0) m_act = r;
    else if (!m_act) begin
      if (r) begin m_act = 1; m_n = 1; end
    end else begin
      if (!r && lvl(m_k, m_n) == 0) m_act = 0;
      else begin
        m_n++;
        if (!r && lvl(m_k, m_n) == 0) m_act = 0;
      end
    end
    expv = m_act ? ((m_k == 0) ? 1'b1 : 1'(lvl(m_k, m_n))) : 1'b0;
    if (we_s) begin
      m_en = d[8]; m_auto = d[9];
      nk = dec_k(d, 1, ill);
      m_bad = ill;
      if (!ill && !en_b && idle_b) m_k = nk;
      void'(dec_k(d, 0, ill2));
      m_bad2 = ill2;
    end
    check(cur_req, sdclk, expv);
    check("R8", bad, m_bad);
    check("R8", bad2, m_bad2);
  endtask

  task automatic wr(logic [16:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) step();
  endtask

  task automatic settle();
    while (m_act) step();
    step(); step();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20517));
    repeat (4) @(posedge clk);
    #2; rst = 1'b0;
    // R1: reset state
    check("R1", sdclk, 1'b0);
    check("R1", bad, 1'b0);
    run(5);
    // R1: ratio held from reset is divide-by-2 (illegal code keeps it)
    wr(enc(3) | enc(5) | 17'h100);
    run(12);
    wr(17'h0); settle();

    // R3: directed even-ratio duty check, divide by 16
    cur_req = "R3";
    wr(enc(4) | 17'h100); run(80);
    cur_req = "R5"; wr(17'h0); settle();

    // R4: pass-through, with one sample in the host-clock low phase
    cur_req = "R4";
    wr(enc(0) | 17'h100); run(4);
    #4; check("R4", sdclk, 1'b0);
    run(6);
    wr(17'h0); settle();

    // R9: reserved bits set, divide by 4
    cur_req = "R9";
    wr(enc(2) | 17'h100 | 17'h0F800); run(30);
    wr(17'h0F800); settle();

    // R2/R5/R7 random trials
    for (int t = 0; t < 20; t++) begin
      int k, per;
      logic [16:0] junk;
      k = int'($urandom % 11);
      per = 1 << k;
      junk = 17'(($urandom % 32) << 11);
      cur_req = (k == 0) ? "R4" : "R2";
      wr(enc(k) | 17'h100 | junk);
      run(2 * per + int'($urandom % per) + 2);
      cur_req = "R7";
      wr(enc((k + 1) % 11) | 17'h100);
      run(per + 3 + int'($urandom % 7));
      cur_req = "R5";
      wr(junk); settle();
    end

    // R6: auto-stop with random busy bursts at divide by 8
    cur_req = "R6";
    wr(enc(3) | 17'h300);
    for (int b = 0; b < 30; b++) begin
      bus_busy = 1'($urandom % 2);
      run(int'($urandom % 40) + 1);
    end
    bus_busy = 1'b0; run(10);
    wr(17'h0); settle();

    // R8: multi-bit code keeps ratio, legal code clears flag
    cur_req = "R8";
    wr(enc(5) | enc(7) | 17'h100); run(40);
    wr(17'h0); settle();
    wr(enc(2) | 17'h100); run(20);
    wr(17'h0); settle();
    // R8: divide-by-1024 code, flagged only where unsupported
    cur_req = "R2";
    wr(enc(10) | 17'h100); run(2100);
    wr(17'h0); settle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule